// File: doc/BRIEF.md
# Configurable SPI Master Shifter

This block is a byte-wide serial master for the SPI bus. Loading a byte into its buffer starts a transfer at once; there is no separate start command. The byte goes out on the data output most significant bit first while the data input is shifted into a receive register. When the eighth bit has been sampled, the received byte replaces the buffer contents and a full flag rises.

Configuration inputs set the clock idle level, whether each output bit leads its clock edge or coincides with it, whether input data is sampled in the middle or at the end of each bit, and the bit-rate source. The bit rate is either a fixed division of the system clock or one half-period per pulse of an external timer tick. The configuration is captured only while the block is idle. A freeze input suspends a transfer exactly where it is, and releasing it continues the transfer with no bit lost. An output-enable signal lets the data output be tri-stated for receive-only use; reception is unaffected.

Top module: `spi_master_shifter`

## Requirements
- R1: A write (`wr_en` high) while `busy` is low starts a transfer on that clock edge: `busy` is high from the next cycle and `sdo` shows bit 7 of the written byte.
- R2: Bits leave most significant first. Bit i of the transfer (i = 0..7, carrying data bit 7-i) is on `sdo` for half-periods 2i and 2i+1.
- R3: While idle `sck` equals the captured idle level `cfg_cpol`; a transfer has exactly 16 half-periods (8 clock periods) and `sck` is back at the idle level when `busy` falls.
- R4: With `cfg_early` = 1, `sck` is at its idle level in even half-periods and active in odd ones, so each bit is valid before its first edge; with `cfg_early` = 0, `sck` is active in even half-periods.
- R5: With `cfg_smp_end` = 0, `sdi` is sampled at the end of half-period 2i (middle of the bit); with `cfg_smp_end` = 1, at the end of half-period 2i+1 (end of the bit).
- R6: `cfg_rate` 0, 1, 2 give a half-period of 2, 8, 32 system clocks (full bit of 4, 16, 64); code 3 advances one half-period per cycle in which `tmr_tick` is high.
- R7: At the end of half-period 15 the received byte is loaded into `rd_data`, `buf_full` is set and `busy` falls in the same cycle; a pulse on `rd_en` clears `buf_full`.
- R8: While `freeze` is high no half-period advances and `sck`, `sdo` and the shift state hold; after release the transfer continues from that point.
- R9: A write while `busy` is high is ignored (neither the outgoing bits nor the loaded result change) and sets `wcol`; `rd_en` clears `wcol`.
- R10: Changes on the configuration inputs while `busy` is high have no effect on the running transfer.
- R11: `sdo_oe` follows the captured `cfg_sdo_en`; with it low, `sdi` is still received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe; starts a transfer when idle |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Buffer read strobe; clears `buf_full` and `wcol` |
| rd_data | output | 8 | Buffer contents (last received byte) |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_early | input | 1 | 1: data leads the first clock edge of each bit |
| cfg_smp_end | input | 1 | 1: sample at end of bit, 0: at middle |
| cfg_rate | input | 2 | Bit-rate source select |
| cfg_sdo_en | input | 1 | Data output driver enable |
| tmr_tick | input | 1 | External timer pulse for rate code 3 |
| freeze | input | 1 | Suspend the transfer in place |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| busy | output | 1 | Transfer in progress |
| buf_full | output | 1 | Received byte waiting in buffer |
| wcol | output | 1 | Write collision seen during a transfer |

## Verification
On every cycle the assertions check that the clock rests at its idle level when idle, that captured configuration cannot move during a transfer, that a freeze holds the phase, divider and data output, that a busy write raises the collision flag and that completion leaves the buffer full with the block idle. The bit order, the clock phase against the data, the choice of sampling point, the rate divisions and the exact resume point after a freeze are only visible in the bench's transfers, which compare every cycle's `sck` and `sdo` to a cycle count and drive `sdi` so that the mid-bit and end-of-bit samples receive different bytes.

// File: rtl/spi_shifter_pkg.sv
package spi_shifter_pkg;

  typedef enum logic [1:0] {
    RATE_DIV_A = 2'd0,
    RATE_DIV_B = 2'd1,
    RATE_DIV_C = 2'd2,
    RATE_TMR   = 2'd3
  } rate_e;

  typedef struct packed {
    logic  cpol;
    logic  early;
    logic  smp_end;
    rate_e rate;
    logic  sdo_en;
  } shifter_cfg_t;

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_shifter_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  freeze,
  input  rate_e rate,
  input  logic  tmr_tick,
  output logic  half_tick
);

  localparam int HALF_A = DIV_A / 2;
  localparam int HALF_B = DIV_B / 2;
  localparam int HALF_C = DIV_C / 2;
  localparam int CW     = $clog2(HALF_C) + 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (rate)
      RATE_DIV_A: lim = CW'(HALF_A - 1);
      RATE_DIV_B: lim = CW'(HALF_B - 1);
      RATE_DIV_C: lim = CW'(HALF_C - 1);
      default:    lim = '0;
    endcase
  end

  always_comb begin
    half_tick = run && !freeze && ((rate == RATE_TMR) ? tmr_tick : (cnt_q == lim));
    if (!run)                             cnt_d = '0;
    else if (freeze || rate == RATE_TMR)  cnt_d = cnt_q;
    else if (half_tick)                   cnt_d = '0;
    else                                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: divider never runs past the selected half-period length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim));

  // R8: divider frozen while the transfer is suspended
  p_cnt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && freeze) |=> $stable(cnt_q));

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [W-1:0]               tx_byte,
  input  logic                       half_tick,
  input  logic                       smp_end,
  input  logic                       sdi,
  output logic                       sdo,
  output logic [$clog2(2*W)-1:0]     phase,
  output logic                       done,
  output logic [W-1:0]               rx_byte
);

  localparam int HALVES = 2 * W;
  localparam int HW     = $clog2(HALVES);

  logic [W-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic [HW-1:0] half_q, half_d;
  logic          samp, end_pt;

  always_comb begin
    end_pt = half_tick && half_q[0];
    samp   = smp_end ? end_pt : (half_tick && !half_q[0]);
    rx_d   = samp ? {rx_q[W-2:0], sdi} : rx_q;

    if (start)       tx_d = tx_byte;
    else if (end_pt) tx_d = {tx_q[W-2:0], 1'b0};
    else             tx_d = tx_q;

    if (start)          half_d = '0;
    else if (half_tick) half_d = half_q + 1'b1;
    else                half_d = half_q;

    done    = half_tick && (half_q == HW'(HALVES - 1));
    rx_byte = rx_d;
    sdo     = tx_q[W-1];
    phase   = half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      half_q <= '0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      half_q <= half_d;
    end
  end

  // R2: the outgoing bit only moves at the end of an odd half-period or at a start
  p_sdo_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(half_tick && half_q[0])) |=> $stable(tx_q));

endmodule

// File: rtl/spi_master_shifter.sv
module spi_master_shifter
  import spi_shifter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cfg_cpol,
  input  logic              cfg_early,
  input  logic              cfg_smp_end,
  input  logic [1:0]        cfg_rate,
  input  logic              cfg_sdo_en,
  input  logic              tmr_tick,
  input  logic              freeze,
  input  logic              sdi,
  output logic              sck,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              buf_full,
  output logic              wcol
);

  localparam int PW = $clog2(2 * DATA_W);

  shifter_cfg_t      cfg_q, cfg_d;
  logic              busy_q, busy_d, full_q, full_d, wcol_q, wcol_d;
  logic [DATA_W-1:0] buf_q, buf_d, rx_byte;
  logic [PW-1:0]     phase;
  logic              start, half_tick, done, core_sdo;

  assign start = wr_en && !busy_q;

  spi_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_q),
    .freeze    (freeze),
    .rate      (cfg_q.rate),
    .tmr_tick  (tmr_tick),
    .half_tick (half_tick)
  );

  spi_shift_core #(.W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tx_byte   (wr_data),
    .half_tick (half_tick),
    .smp_end   (cfg_q.smp_end),
    .sdi       (sdi),
    .sdo       (core_sdo),
    .phase     (phase),
    .done      (done),
    .rx_byte   (rx_byte)
  );

  always_comb begin
    cfg_d = busy_q ? cfg_q
                   : '{cpol: cfg_cpol, early: cfg_early, smp_end: cfg_smp_end,
                       rate: rate_e'(cfg_rate), sdo_en: cfg_sdo_en};

    if (start)     busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
    else           busy_d = busy_q;

    if (done)       full_d = 1'b1;
    else if (rd_en) full_d = 1'b0;
    else            full_d = full_q;

    if (busy_q && wr_en) wcol_d = 1'b1;
    else if (rd_en)      wcol_d = 1'b0;
    else                 wcol_d = wcol_q;

    buf_d = done ? rx_byte : buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      full_q <= 1'b0;
      wcol_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      busy_q <= busy_d;
      full_q <= full_d;
      wcol_q <= wcol_d;
      buf_q  <= buf_d;
    end
  end

  always_comb begin
    if (busy_q) sck = cfg_q.cpol ^ (cfg_q.early ? phase[0] : ~phase[0]);
    else        sck = cfg_q.cpol;
    sdo      = core_sdo;
    sdo_oe   = cfg_q.sdo_en;
    busy     = busy_q;
    buf_full = full_q;
    wcol     = wcol_q;
    rd_data  = buf_q;
  end

  // R3: clock rests at the captured idle level whenever no transfer runs
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sck == cfg_q.cpol));

  // R10: captured configuration is frozen for the length of a transfer
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> $stable(cfg_q));

  // R9: a write during a transfer leaves the collision flag set
  p_wcol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en) |=> wcol_q);

  // R7: completion leaves the buffer full and the block idle
  p_full_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (full_q && !busy_q));

  // R8: a frozen transfer keeps its phase and outgoing bit
  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && freeze) |=> ($stable(phase) && $stable(core_sdo) && busy_q));

endmodule

// File: tb/tb_spi_master_shifter.sv
module tb_spi_master_shifter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, cfg_cpol, cfg_early, cfg_smp_end, cfg_sdo_en;
  logic       tmr_tick, freeze, sdi;
  logic [1:0] cfg_rate;
  logic [7:0] wr_data, rd_data;
  logic       sck, sdo, sdo_oe, busy, buf_full, wcol;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_master_shifter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .cfg_cpol(cfg_cpol), .cfg_early(cfg_early),
    .cfg_smp_end(cfg_smp_end), .cfg_rate(cfg_rate), .cfg_sdo_en(cfg_sdo_en),
    .tmr_tick(tmr_tick), .freeze(freeze), .sdi(sdi), .sck(sck), .sdo(sdo),
    .sdo_oe(sdo_oe), .busy(busy), .buf_full(buf_full), .wcol(wcol)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One full transfer; expected values are derived from the count of
  // non-frozen cycles since the start edge.
  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] a, input logic [7:0] b,
                          input bit cpol, input bit early, input bit smpend,
                          input logic [1:0] rate, input bit oe,
                          input int frz_every, input bit collide);
    int h_len;
    int n;
    int cyc;
    int h;
    bit frz;
    bit exp_sck;
    h_len = (rate == 2'd0) ? 2 : (rate == 2'd1) ? 8 : (rate == 2'd2) ? 32 : 3;
    @(negedge clk);
    cfg_cpol = cpol; cfg_early = early; cfg_smp_end = smpend;
    cfg_rate = rate; cfg_sdo_en = oe;
    wr_data = tx; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    n = 0; cyc = 0;
    chk(busy == 1'b1, "R1 busy after write", busy, 1);
    chk(sdo == tx[7], "R1 first bit on sdo", sdo, tx[7]);
    while (n < 16 * h_len) begin
      h = n / h_len;
      exp_sck = cpol ^ (early ? h[0] : ~h[0]);
      chk(busy == 1'b1, "R3 busy during transfer", busy, 1);
      chk(sck == exp_sck, early ? "R4 sck phase early" : "R4 sck phase late", sck, exp_sck);
      chk(sdo == tx[7 - h/2], "R2 sdo bit order", sdo, tx[7 - h/2]);
      chk(sdo_oe == oe, "R11 sdo_oe", sdo_oe, oe);
      sdi = h[0] ? b[7 - h/2] : a[7 - h/2];
      tmr_tick = (rate == 2'd3) && ((n % h_len) == h_len - 1);
      frz = (frz_every != 0) && ((cyc % frz_every) == 0);
      freeze = frz;
      // R10: disturb configuration mid-transfer, restore before the end
      if (n == 3) begin
        cfg_cpol = ~cpol; cfg_early = ~early; cfg_smp_end = ~smpend;
        cfg_rate = rate ^ 2'd1; cfg_sdo_en = ~oe;
      end
      if (n == 7) begin
        cfg_cpol = cpol; cfg_early = early; cfg_smp_end = smpend;
        cfg_rate = rate; cfg_sdo_en = oe;
      end
      // R9: write attempt during the transfer
      wr_en = collide && (n == 5) && !frz;
      wr_data = collide ? ~tx : tx;
      @(negedge clk);
      wr_en = 1'b0;
      if (!frz) n++;
      cyc++;
    end
    freeze = 1'b0; tmr_tick = 1'b0;
    chk(busy == 1'b0, "R3 busy falls after 16 halves", busy, 0);
    chk(sck == cpol, "R3 sck idle after transfer", sck, cpol);
    chk(buf_full == 1'b1, "R7 buf_full set", buf_full, 1);
    chk(rd_data == (smpend ? b : a), smpend ? "R5 end-of-bit sample" : "R5 mid-bit sample",
        rd_data, smpend ? b : a);
    chk(wcol == collide, "R9 wcol flag", wcol, collide);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(buf_full == 1'b0, "R7 rd_en clears buf_full", buf_full, 0);
    chk(wcol == 1'b0, "R9 rd_en clears wcol", wcol, 0);
    chk(sck == cpol, "R3 sck idle between transfers", sck, cpol);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 0; rd_en = 0; wr_data = 0; cfg_cpol = 0; cfg_early = 0;
    cfg_smp_end = 0; cfg_rate = 0; cfg_sdo_en = 0; tmr_tick = 0; freeze = 0; sdi = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && buf_full == 0 && wcol == 0, "R1 reset flags", {busy, buf_full, wcol}, 0);
    chk(sck == 0 && sdo_oe == 0, "R3 reset sck", {sck, sdo_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 R5: sweep clock polarity, phase and sample point at the fastest rate
    for (int m = 0; m < 8; m++)
      run_xfer(8'hA5 ^ 8'(m * 37), 8'h3C + 8'(m), 8'hC1 - 8'(m * 11),
               m[0], m[1], m[2], 2'd0, 1'b1, 0, 1'b0);
    // R6: slower divisions and the timer source
    run_xfer(8'h96, 8'h5A, 8'hE7, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 0, 1'b0);
    run_xfer(8'h0F, 8'h81, 8'h7E, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1, 0, 1'b0);
    run_xfer(8'hC3, 8'h24, 8'hDB, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 0, 1'b0);
    // R8: freezes at two spacings, on divided and timer rates
    run_xfer(8'h6D, 8'h92, 8'h4B, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 3, 1'b0);
    run_xfer(8'hB4, 8'h1E, 8'hF0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 2, 1'b0);
    // R9: collision writes
    run_xfer(8'h55, 8'hAA, 8'h33, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 0, 1'b1);
    run_xfer(8'hE1, 8'h17, 8'h8C, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 0, 1'b1);
    // R11: receive-only with output driver off
    run_xfer(8'hFF, 8'h69, 8'h96, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 0, 1'b0);
    run_xfer(8'h00, 8'hD2, 8'h2D, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 4, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule